// File: doc/BRIEF.md
# CSR Access Permission Checker

This block decides whether an instruction that touches a control-and-status register may go ahead. Each request carries the 12-bit register address and the instruction form: swap, or a set-bits / clear-bits form together with its source field, which is the source register index or the immediate. It also carries the hart's current privilege level, its virtualization bit, the presence flags of the supervisor and hypervisor extensions, and a flag from the register-file decoder that says whether the address exists. The block works out from the form whether the access writes. It then returns one of three verdicts: go ahead, raise an illegal-instruction trap, or raise a virtual-instruction trap.

The verdict comes from the address alone plus the hart state. Address bits [9:8] give the lowest privilege that may touch the register. Bits [11:10] equal to 3 mark it as read-only. When the hart runs in supervisor mode with virtualization off, it counts as the hypervisor-supervisor level for the comparison. A request is registered once. The verdict appears with a valid flag exactly one cycle after the request.

Top module: `csr_gate`

## Requirements
- R1: While reset is low, and in the first cycle after it, rsp_valid is 0 and rsp_result is 00.
- R2: rsp_valid equals req_valid of the previous cycle. rsp_result is 00 whenever rsp_valid is 0, and never takes the value 11.
- R3: A request with addr_impl low yields 01 (illegal), whatever the privilege, virtualization bit or other checks say.
- R4: For an implemented address whose bits [9:8] are 1 while has_s is low, or are 2 while has_h is low, the result is 01.
- R5: A write to an address with bits [11:10] equal to 3 is a violation. A read of such an address is not.
- R6: The effective privilege is 2 when priv is 1 (supervisor) and virt is 0. Otherwise it equals priv (U=0, S=1, M=3). An effective privilege below address bits [9:8] is a violation.
- R7: A violation yields 10 (virtual) when virt is 1 and address bits [9:8] are at most 2. Any other violation yields 01.
- R8: The access writes when form_swap is 1. For set and clear forms (form_swap 0) it writes only when src_field is nonzero.
- R9: An implemented address that passes the R4 extension check and has no violation yields 00 (allowed).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| csr_addr | input | 12 | Register address of the access |
| form_swap | input | 1 | 1 for swap forms, 0 for set/clear forms |
| src_field | input | 5 | Source register index or immediate |
| priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt | input | 1 | Virtualization bit |
| has_s | input | 1 | Supervisor extension present |
| has_h | input | 1 | Hypervisor extension present |
| addr_impl | input | 1 | Address exists in the register file |
| rsp_valid | output | 1 | Verdict valid |
| rsp_result | output | 2 | 00 allowed, 01 illegal, 10 virtual |

## Verification
The sweep takes every combination of the top address nibble with each privilege, virtualization state, extension flag pair, implemented flag and instruction form, and sends each one with both a zero and a nonzero source field. Read-only nibbles seen with a zero and a nonzero set/clear source show that write intent comes from the source field and not from the form alone. Supervisor-mode cases with the virtualization bit on and off separate the privilege promotion from the virtual-trap choice. Unimplemented cases with virtualization on show that the existence check wins over every other check. An idle cycle after the sweep checks that the verdict clears.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

    typedef enum logic [1:0] {
        RES_OK      = 2'b00,
        RES_ILLEGAL = 2'b01,
        RES_VIRTUAL = 2'b10
    } csr_res_e;

    localparam logic [1:0] LVL_USER  = 2'd0;
    localparam logic [1:0] LVL_SUPER = 2'd1;
    localparam logic [1:0] LVL_HYPER = 2'd2;
    localparam logic [1:0] LVL_MACH  = 2'd3;

    typedef struct packed {
        logic     vld;
        csr_res_e res;
    } rsp_t;

endpackage

// File: rtl/csr_wr_intent.sv
module csr_wr_intent #(
    parameter int SRC_W = 5
) (
    input  logic             form_swap,
    input  logic [SRC_W-1:0] src_field,
    output logic             wr_intent
);
    // swap always writes; set/clear write only with a nonzero source
    always_comb begin
        wr_intent = form_swap | (|src_field);
    end
endmodule

// File: rtl/csr_perm_eval.sv
module csr_perm_eval
    import csr_gate_pkg::*;
(
    input  logic [3:0] addr_hi,
    input  logic       wr_intent,
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       has_s,
    input  logic       has_h,
    input  logic       addr_impl,
    output csr_res_e   verdict
);
    logic [1:0] need_lvl;
    logic       read_only;
    logic [1:0] eff_lvl;
    logic       ext_missing;
    logic       violation;

    always_comb begin
        need_lvl    = addr_hi[1:0];
        read_only   = (addr_hi[3:2] == 2'b11);
        eff_lvl     = (priv == LVL_SUPER && !virt) ? LVL_HYPER : priv;
        ext_missing = (need_lvl == LVL_SUPER && !has_s) ||
                      (need_lvl == LVL_HYPER && !has_h);
        violation   = (wr_intent && read_only) || (eff_lvl < need_lvl);

        if (!addr_impl) begin
            verdict = RES_ILLEGAL;
        end else if (ext_missing) begin
            verdict = RES_ILLEGAL;
        end else if (violation) begin
            verdict = (virt && need_lvl <= LVL_HYPER) ? RES_VIRTUAL : RES_ILLEGAL;
        end else begin
            verdict = RES_OK;
        end
    end

    always_comb begin
        if (verdict == RES_VIRTUAL) begin
            a_virtual_only_when_virt_r7: assert (virt && addr_impl);
        end
    end
endmodule

// File: rtl/csr_gate.sv
module csr_gate
    import csr_gate_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SRC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              form_swap,
    input  logic [SRC_W-1:0]  src_field,
    input  logic [1:0]        priv,
    input  logic              virt,
    input  logic              has_s,
    input  logic              has_h,
    input  logic              addr_impl,
    output logic              rsp_valid,
    output logic [1:0]        rsp_result
);
    localparam int HI_LSB = ADDR_W - 4;

    logic     wr_intent;
    csr_res_e verdict;
    rsp_t     rsp_d, rsp_q;
    logic     unused_lo;

    assign unused_lo = ^csr_addr[HI_LSB-1:0];

    csr_wr_intent #(.SRC_W(SRC_W)) u_wr (
        .form_swap (form_swap),
        .src_field (src_field),
        .wr_intent (wr_intent)
    );

    csr_perm_eval u_eval (
        .addr_hi   (csr_addr[ADDR_W-1:HI_LSB]),
        .wr_intent (wr_intent),
        .priv      (priv),
        .virt      (virt),
        .has_s     (has_s),
        .has_h     (has_h),
        .addr_impl (addr_impl),
        .verdict   (verdict)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = req_valid;
        rsp_d.res = req_valid ? verdict : RES_OK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '{vld: 1'b0, res: RES_OK};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.vld;
    assign rsp_result = rsp_q.res;

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_result == 2'b00));
    p_no_code3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_result != 2'b11);
    p_unimpl_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !addr_impl) |=> rsp_result == 2'b01);
    p_ext_missing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && addr_impl &&
         ((csr_addr[HI_LSB+1:HI_LSB] == 2'd1 && !has_s) ||
          (csr_addr[HI_LSB+1:HI_LSB] == 2'd2 && !has_h))) |=> rsp_result == 2'b01);
    p_no_virtual_without_v_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !virt) |=> rsp_result != 2'b10);
    p_machine_reg_no_virtual_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && csr_addr[HI_LSB+1:HI_LSB] == 2'd3) |=> rsp_result != 2'b10);
endmodule

// File: tb/csr_gate_bench.sv
module csr_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        form_swap = 1'b0;
    logic [4:0]  src_field = '0;
    logic [1:0]  priv = '0;
    logic        virt = 1'b0;
    logic        has_s = 1'b0;
    logic        has_h = 1'b0;
    logic        addr_impl = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    csr_gate u_csr_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .csr_addr(csr_addr),
        .form_swap(form_swap), .src_field(src_field), .priv(priv), .virt(virt),
        .has_s(has_s), .has_h(has_h), .addr_impl(addr_impl),
        .rsp_valid(rsp_valid), .rsp_result(rsp_result)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected verdict from the requirements, plus the rule that decided it
    task automatic model(input int hi, input int pv, input bit v, input bit s, input bit h,
                         input bit impl, input bit sw, input int src,
                         output logic [1:0] res, output string tag);
        int  need = hi % 4;
        bit  ro   = (hi / 4) == 3;
        bit  wr   = sw || (src != 0);                 // R8
        int  eff  = (pv == 1 && !v) ? 2 : pv;         // R6
        if (!impl) begin
            res = 2'b01; tag = "R3";
        end else if ((need == 1 && !s) || (need == 2 && !h)) begin
            res = 2'b01; tag = "R4";
        end else if ((wr && ro) || eff < need) begin
            res = (v && need <= 2) ? 2'b10 : 2'b01;
            tag = (wr && ro) ? "R5 R8 R7" : "R6 R7";
        end else begin
            res = 2'b00; tag = ro ? "R9 R8" : "R9 R6";
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int idx = 0;
        repeat (3) @(posedge clk);
        #1 check("R1 reset", {rsp_valid, rsp_result}, 3'b000);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 check("R1 after reset", {rsp_valid, rsp_result}, 3'b000);

        for (int hi = 0; hi < 16; hi++)
        for (int pv = 0; pv < 4; pv++) begin
            if (pv == 2) continue;
            for (int v = 0; v < 2; v++)
            for (int s = 0; s < 2; s++)
            for (int h = 0; h < 2; h++)
            for (int im = 0; im < 2; im++)
            for (int sw = 0; sw < 2; sw++)
            for (int z = 0; z < 2; z++) begin
                logic [1:0] er;
                string      tg;
                int         src = (z == 0) ? 0 : 1 + (idx % 31);
                @(negedge clk);
                req_valid = 1'b1;
                csr_addr  = {4'(hi), 8'((idx * 37) & 255)};
                priv = 2'(pv); virt = 1'(v); has_s = 1'(s); has_h = 1'(h);
                addr_impl = 1'(im); form_swap = 1'(sw); src_field = 5'(src);
                model(hi, pv, 1'(v), 1'(s), 1'(h), 1'(im), 1'(sw), src, er, tg);
                @(posedge clk);
                #1 check({tg, " R2"}, {rsp_valid, rsp_result}, {1'b1, er});
                idx++;
            end
        end

        @(negedge clk) req_valid = 1'b0;
        @(posedge clk);
        #1 check("R2 idle", {rsp_valid, rsp_result}, 3'b000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule